// File: doc/BRIEF.md
# Configuration Bitfile Payload Extractor

This block is a byte-stream filter that sits between a store holding a vendor configuration file and the serial loader of a programmable device. The file opens with a text header of no fixed length, so the block cannot count its way to the payload. Instead it searches the incoming bytes for a two-byte lock pattern (`0x65` then `0x00`). This pattern is the size-field tag followed by the top byte of a four-byte big-endian size. That top byte is always zero, because the size never needs more than three bytes. The block drops the three remaining size bytes, keeps them on an output port for later checking, and forwards every later byte unchanged. When the upstream marks the final byte of the file, the block appends a fixed number of `0xFF` pad bytes and then returns to searching for the next file.

Both byte interfaces are valid/ready. A byte moves when valid and ready are high at the same rising clock edge. While searching and while skipping the size bytes, the input is always ready and the output is idle. While passing payload, the input ready follows the output ready combinationally, so back-pressure on the output stalls the input one-for-one and no byte is lost or repeated. While padding, the input is held not-ready. A pad byte that has been offered stays offered, with unchanged data, until it is taken. The upstream is expected to hold a byte and its end marker stable until they are accepted.

Top module: `bitfile_payload_extract`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `sync_found` is 0 and `payload_len` is 0.
- R2: No byte is offered on the output before the lock pattern has been accepted, and the input stays ready while searching.
- R3: The lock pattern is an accepted `0x65` immediately followed by an accepted `0x00`. A `0x65` followed by any other value does not lock, and a second `0x65` in that place is tested again as a pattern start. `sync_found` reads 1 from the cycle after the `0x00` is accepted.
- R4: The three bytes accepted after the lock pattern are not forwarded. They are loaded most significant first into `payload_len` (bits 23:16, 15:8, 7:0), which holds its value until the next lock.
- R5: Every byte accepted after the three size bytes is forwarded unchanged and in order, including the byte flagged with `in_last`. Lock-pattern values inside the payload have no effect.
- R6: While payload is passing, `in_ready` equals `out_ready`, `out_valid` equals `in_valid` and `out_data` equals `in_data`, so each accepted input byte leaves in the same cycle.
- R7: After the byte flagged with `in_last` is forwarded, exactly `PAD_COUNT` bytes of value `0xFF` are offered. `in_ready` is 0 during them, and `out_last` is 1 only on the final pad byte.
- R8: After the final pad byte is accepted, the block returns to searching and `sync_found` reads 0 in the next cycle.
- R9: An accepted byte flagged with `in_last` before the payload starts (while searching or skipping) ends the attempt: nothing is forwarded, no pad follows, and the next byte starts a fresh search, even if the flagged byte was `0x65`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the file |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final pad byte |
| sync_found | output | 1 | Lock pattern seen; high until padding completes |
| payload_len | output | 24 | Size field captured after the lock pattern |

## Verification
The bench sweeps header shapes, payload lengths and three output-stall rates. One header holds a decoy `0x65 0x12`, which would lock early and emit header bytes. Another holds `0x65 0x65 0x00`, which would never lock if the repeated `0x65` were not tested again. The payloads carry `0xFF`, `0x65` and `0x00` in their first bytes. This shows that locking is disarmed after sync and that the first size byte is not mistaken for payload, either of which would corrupt or shift the output. End markers placed in the header and in the size field check that an aborted attempt produces neither pad bytes nor a stale lock. Pad checks count the `0xFF` bytes, the single `out_last` and the held-off input, where an off-by-one counter or a leaky ready would show.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_SKIP   = 2'd1,
    ST_PASS   = 2'd2,
    ST_PAD    = 2'd3
  } bps_state_e;
endpackage

// File: rtl/bps_sync_finder.sv
module bps_sync_finder #(
  parameter int          W      = 8,
  parameter logic [W-1:0] LEAD  = 8'h65,
  parameter logic [W-1:0] TRAIL = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         clear,
  input  logic [W-1:0] data,
  output logic         hit
);
  logic armed;

  // a pattern completes when the previous accepted byte was LEAD
  assign hit = take && armed && (data == TRAIL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) armed <= 1'b0;
    else if (take)       armed <= (data == LEAD);
  end
endmodule

// File: rtl/bps_len_skip.sv
module bps_len_skip #(
  parameter int W         = 8,
  parameter int LEN_BYTES = 3,
  localparam int LW       = W * LEN_BYTES,
  localparam int CW       = $clog2(LEN_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          take,
  input  logic [W-1:0]  data,
  output logic          done,
  output logic [LW-1:0] len
);
  logic [CW-1:0] cnt;

  assign done = take && (cnt == CW'(LEN_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= '0;
    end else if (start) begin
      cnt <= '0;
      len <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (LEN_BYTES == 1) len <= LW'(data);
      else                len <= {len[LW-W-1:0], data};
    end
  end
endmodule

// File: rtl/bps_pad_gen.sv
module bps_pad_gen #(
  parameter int PAD_COUNT = 4,
  localparam int CW       = $clog2(PAD_COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic final_o
);
  logic [CW-1:0] cnt;

  assign final_o = (cnt == CW'(PAD_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || start) cnt <= '0;
    else if (step)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bitfile_payload_extract.sv
module bitfile_payload_extract
  import bps_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          LEN_BYTES = 3,
  parameter int          PAD_COUNT = 4,
  parameter logic [W-1:0] SYNC_LEAD = 8'h65,
  parameter logic [W-1:0] SYNC_TRAIL = 8'h00,
  parameter logic [W-1:0] PAD_BYTE  = 8'hFF,
  localparam int         LW        = W * LEN_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_last,
  output logic          sync_found,
  output logic [LW-1:0] payload_len
);
  bps_state_e state, state_nx;

  logic acc_in, acc_out;
  logic sync_hit, len_done, pad_final;

  assign acc_in  = in_valid && in_ready;
  assign acc_out = out_valid && out_ready;

  bps_sync_finder #(.W(W), .LEAD(SYNC_LEAD), .TRAIL(SYNC_TRAIL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .take (acc_in && (state == ST_SEARCH)),
    .clear((state != ST_SEARCH) || (acc_in && in_last)),
    .data (in_data),
    .hit  (sync_hit)
  );

  bps_len_skip #(.W(W), .LEN_BYTES(LEN_BYTES)) u_len (
    .clk  (clk),
    .rst_n(rst_n),
    .start(state == ST_SEARCH && acc_in && !in_last && sync_hit),
    .take (acc_in && (state == ST_SKIP)),
    .data (in_data),
    .done (len_done),
    .len  (payload_len)
  );

  bps_pad_gen #(.PAD_COUNT(PAD_COUNT)) u_pad (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (state != ST_PAD),
    .step   (acc_out && (state == ST_PAD)),
    .final_o(pad_final)
  );

  // handshake and data steering per state
  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = PAD_BYTE;
    out_last  = 1'b0;
    case (state)
      ST_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      ST_PAD: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_last  = pad_final;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_SEARCH: if (acc_in && !in_last && sync_hit) state_nx = ST_SKIP;
      ST_SKIP: begin
        if (acc_in && in_last) state_nx = ST_SEARCH;
        else if (len_done)     state_nx = ST_PASS;
      end
      ST_PASS:   if (acc_in && in_last)     state_nx = ST_PAD;
      ST_PAD:    if (acc_out && pad_final)  state_nx = ST_SEARCH;
      default:   state_nx = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_SEARCH;
    else        state <= state_nx;
  end

  assign sync_found = (state != ST_SEARCH);
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter logic [7:0] PAD_BYTE = 8'hFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic        sync_found
);
  // R2
  quiet_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_found |-> (!out_valid && in_ready));

  // R3
  lock_after_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_found) |-> $past(in_valid && in_ready && in_data == 8'h00 && !in_last));

  // R6
  same_cycle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |-> (out_ready && out_data == in_data));

  // R7
  pad_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_data == PAD_BYTE && !in_ready));

  // R7
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_ready && sync_found) |=> (out_valid && $stable(out_data)));

  // R8
  unlock_after_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !sync_found);
endmodule

bind bitfile_payload_extract bps_checker #(.PAD_BYTE(PAD_BYTE)) u_bps_chk (.*);

// File: tb/bitfile_payload_extract_test.sv
module bitfile_payload_extract_test;
  localparam int PAD = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_last;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic        sync_found;
  logic [23:0] payload_len;

  int checks = 0;
  int fails  = 0;
  int rmode  = 0;
  int rcnt   = 0;

  logic [7:0] got_data [0:255];
  logic       got_last [0:255];
  logic       got_rdy  [0:255];
  int         got_cnt = 0;

  bitfile_payload_extract #(.PAD_COUNT(PAD)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .sync_found(sync_found), .payload_len(payload_len)
  );

  always #5 clk = ~clk;

  // output stall pattern: mode 0 always ready, mode k ready one cycle in k+1
  always @(negedge clk) begin
    rcnt = rcnt + 1;
    out_ready = (rmode == 0) || ((rcnt % (rmode + 1)) == 0);
  end

  // output monitor, sampled after inputs settle and before the next edge
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready && got_cnt < 256) begin
      got_data[got_cnt] = out_data;
      got_last[got_cnt] = out_last;
      got_rdy[got_cnt]  = in_ready;
      got_cnt = got_cnt + 1;
    end
  end

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_test();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    forever begin
      #2;
      taken = in_ready;
      @(negedge clk);
      if (taken) break;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  function automatic logic [7:0] pay_byte(input int i, input int v);
    if (i == 0) return 8'hFF;
    if (i == 1) return 8'h65;
    if (i == 2) return 8'h00;
    return 8'((i * 29 + v * 7) & 255);
  endfunction

  task automatic run_file(input int v, input int n, input int mode);
    logic [23:0] exp_len;
    int wait_cyc;
    rmode   = mode;
    got_cnt = 0;
    exp_len = {8'h02, 8'hC0, 8'(n)};
    send(8'h00, 1'b0);
    send(8'h09, 1'b0);
    if (v == 0) begin
      send(8'h65, 1'b0);
      send(8'h12, 1'b0);
      #3;
      // R3 decoy 0x65 0x12 must not lock
      chk(sync_found == 1'b0, "R3", "decoy lock", int'(sync_found), 0);
      send(8'h61, 1'b0);
    end else if (v == 1) begin
      send(8'h65, 1'b0);
    end
    send(8'h65, 1'b0);
    send(8'h00, 1'b0);
    #3;
    // R3 lock visible after the 0x00 is accepted
    chk(sync_found == 1'b1, "R3", "sync_found after pattern", int'(sync_found), 1);
    send(exp_len[23:16], 1'b0);
    send(exp_len[15:8], 1'b0);
    send(exp_len[7:0], 1'b0);
    #3;
    // R2 R4 header and size bytes are never forwarded
    chk(got_cnt == 0, "R4", "bytes out before payload", got_cnt, 0);
    chk(payload_len == exp_len, "R4", "payload_len", int'(payload_len), int'(exp_len));
    for (int i = 0; i < n; i++) send(pay_byte(i, v), i == n - 1);
    wait_cyc = 0;
    while (got_cnt < n + PAD && wait_cyc < 300) begin
      @(negedge clk);
      wait_cyc++;
    end
    idle(3);
    // R5 R7 byte count
    chk(got_cnt == n + PAD, "R7", "output byte count", got_cnt, n + PAD);
    for (int i = 0; i < n && i < got_cnt; i++) begin
      // R5 payload forwarded in order
      chk(got_data[i] == pay_byte(i, v), "R5", "payload byte", int'(got_data[i]),
          int'(pay_byte(i, v)));
      chk(got_last[i] == 1'b0, "R7", "out_last on payload", int'(got_last[i]), 0);
    end
    for (int i = n; i < n + PAD && i < got_cnt; i++) begin
      // R7 pad bytes
      chk(got_data[i] == 8'hFF, "R7", "pad byte", int'(got_data[i]), 8'hFF);
      chk(got_last[i] == (i == n + PAD - 1), "R7", "out_last on pad", int'(got_last[i]),
          int'(i == n + PAD - 1));
      chk(got_rdy[i] == 1'b0, "R7", "in_ready during pad", int'(got_rdy[i]), 0);
    end
    // R8 back to search
    chk(sync_found == 1'b0, "R8", "sync_found after pad", int'(sync_found), 0);
    // R4 length held after lock ends
    chk(payload_len == exp_len, "R4", "payload_len held", int'(payload_len), int'(exp_len));
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    in_last = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(sync_found == 1'b0, "R1", "sync_found", int'(sync_found), 0);
    chk(payload_len == 24'd0, "R1", "payload_len", int'(payload_len), 0);

    // R6 sweep of stall rates, header shapes and payload lengths
    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 3; v++)
        for (int n = 1; n <= 6; n++)
          run_file(v, n, m);

    // R9 end marker inside the size field aborts
    rmode = 1;
    got_cnt = 0;
    send(8'h01, 1'b0);
    send(8'h65, 1'b0);
    send(8'h00, 1'b0);
    send(8'h02, 1'b0);
    send(8'hC0, 1'b1);
    idle(12);
    chk(got_cnt == 0, "R9", "output after abort in skip", got_cnt, 0);
    chk(sync_found == 1'b0, "R9", "sync_found after abort", int'(sync_found), 0);

    // R9 end marker on 0x65 while searching starts a fresh search
    send(8'h65, 1'b1);
    send(8'h00, 1'b0);
    #3;
    chk(sync_found == 1'b0, "R9", "lock across end marker", int'(sync_found), 0);
    idle(4);
    chk(got_cnt == 0, "R2", "output while searching", got_cnt, 0);

    // recovery after aborts
    run_file(1, 4, 2);
    run_file(2, 1, 0);

    finish_test();
  end
endmodule